// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and memory. It takes stores from the processor and holds them so the processor does not stall on the memory write. Each slot covers one aligned block of four 32-bit words and keeps one valid bit per byte. A new store is compared with every occupied slot. If its block is already held, its bytes are folded into that slot. Several stores to nearby words or bytes then leave the buffer as a single multi-word write with a byte mask.

Slots go out to memory through a valid/ready drain port, oldest first. A read miss on its way to memory can look up the buffer through a plain read-check port. Any buffered bytes for that block come back at once, with the newest value of each byte winning. While a read miss that finds nothing in the buffer is pending, no new drain is started, so the read reaches memory ahead of the older writes.

The store port is valid/ready. `st_ready` falls only when every slot is occupied and the store has no slot it may merge into. A store is taken on any rising edge where both `st_valid` and `st_ready` are high. The drain port is also valid/ready. Once `dr_valid` rises, the address, mask and data on the drain port hold steady until the edge where `dr_ready` is high.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `dr_valid` is 0, `rd_hit` is 0 and `st_ready` is 1.
- R2: `st_addr` is a word address. Bits [1:0] pick the word within the block and the upper bits are the block tag. Byte lane b of word w maps to mask bit 4*w+b and to data bits [(4*w+b)*8 +: 8].
- R3: A store whose tag matches an occupied slot that is not being drained merges into that slot. The later write wins on any byte lane that both stores enable. The block then leaves as one drain write whose mask is the union of the merged byte enables.
- R4: With all DEPTH slots occupied, `st_ready` is 0 for a store that has no slot to merge into, and 1 for a store that does.
- R5: Slots drain in the order they were allocated, oldest first.
- R6: While `dr_valid` is 1 and `dr_ready` is 0, `dr_valid`, `dr_addr`, `dr_mask` and `dr_data` stay unchanged.
- R7: While `rd_req` is 1 and `rd_hit` is 0, no new drain is offered. Once `rd_req` falls, a waiting slot is offered within two cycles.
- R8: `rd_hit` is 1 when any occupied slot holds the tag `rd_addr`. `rd_mask` is then the union of the buffered byte masks for that tag, and `rd_data` carries the newest buffered value of each masked byte.
- R9: A slot being offered on the drain port takes no further merges. A store to its block allocates a new slot, and that slot drains after it.
- R10: A slot is freed on the drain handshake. With no slot occupied, `dr_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 30 | Store word address (tag and word index) |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| dr_valid | output | 1 | Drain write offered |
| dr_ready | input | 1 | Memory takes the drain write |
| dr_addr | output | 28 | Drain block tag |
| dr_data | output | 128 | Drain block data |
| dr_mask | output | 16 | Drain byte mask |
| rd_req | input | 1 | Read miss pending toward memory |
| rd_addr | input | 28 | Block tag of the pending read |
| rd_hit | output | 1 | Buffer holds bytes of that block |
| rd_mask | output | 16 | Bytes forwarded from the buffer |
| rd_data | output | 128 | Forwarded bytes, newest value per byte |

## Verification
The assertions check on every cycle that the drain port stays still while it is stalled. They also check that a read miss with no hit keeps a new drain from starting, that back-pressure on stores appears only when the buffer is full, and that no drain or forward ever comes with an empty mask. The directed scenarios are the only way to show the values themselves. These are the merged byte contents, the oldest-first drain order, the refusal to merge into a slot already being drained, and which byte value wins when two slots hold the same block.

// File: rtl/merge_wbuf_pkg.sv
package merge_wbuf_pkg;
  typedef enum logic {
    DRN_IDLE = 1'b0,
    DRN_BUSY = 1'b1
  } drn_state_e;
endpackage

// File: rtl/merge_wbuf_match.sv
module merge_wbuf_match #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 28
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [DEPTH-1:0]            occ,
  input  logic [TAG_W-1:0]            key,
  output logic [DEPTH-1:0]            hit
);
  // one comparator per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = occ[i] && (tags[i] == key);
  end
endmodule

// File: rtl/merge_wbuf_fwd.sv
module merge_wbuf_fwd #(
  parameter int DEPTH = 4,
  parameter int NB    = 16,
  parameter int PTR_W = 2
) (
  input  logic [DEPTH-1:0]            sel,
  input  logic [DEPTH-1:0][NB-1:0]    masks,
  input  logic [DEPTH-1:0][NB*8-1:0]  datas,
  input  logic [PTR_W-1:0]            head,
  output logic [NB-1:0]               out_mask,
  output logic [NB*8-1:0]             out_data
);
  // walk from oldest to newest so younger slots overwrite older bytes
  always_comb begin
    out_mask = '0;
    out_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = (int'(head) + k) % DEPTH;
      for (int b = 0; b < NB; b++) begin
        if (sel[idx] && masks[idx][b]) begin
          out_mask[b]         = 1'b1;
          out_data[b*8 +: 8]  = datas[idx][b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32,
  parameter int WPE    = 4,
  parameter int DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        st_valid,
  output logic                        st_ready,
  input  logic [TAG_W+$clog2(WPE)-1:0] st_addr,
  input  logic [DATA_W-1:0]           st_data,
  input  logic [DATA_W/8-1:0]         st_be,
  output logic                        dr_valid,
  input  logic                        dr_ready,
  output logic [TAG_W-1:0]            dr_addr,
  output logic [WPE*DATA_W-1:0]       dr_data,
  output logic [WPE*DATA_W/8-1:0]     dr_mask,
  input  logic                        rd_req,
  input  logic [TAG_W-1:0]            rd_addr,
  output logic                        rd_hit,
  output logic [WPE*DATA_W/8-1:0]     rd_mask,
  output logic [WPE*DATA_W-1:0]       rd_data
);
  import merge_wbuf_pkg::*;

  localparam int BPW    = DATA_W / 8;
  localparam int NB     = WPE * BPW;
  localparam int ENT_W  = NB * 8;
  localparam int WIDX_W = $clog2(WPE);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // slot storage
  logic [DEPTH-1:0]            ent_occ;
  logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
  logic [DEPTH-1:0][NB-1:0]    ent_mask;
  logic [DEPTH-1:0][ENT_W-1:0] ent_data;

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;
  drn_state_e       drn_q;

  // store decode
  logic [WIDX_W-1:0] st_word;
  logic [TAG_W-1:0]  st_tag;
  logic [NB-1:0]     wr_mask;
  logic [ENT_W-1:0]  wr_data;

  assign st_word = st_addr[WIDX_W-1:0];
  assign st_tag  = st_addr[TAG_W+WIDX_W-1:WIDX_W];
  assign wr_mask = {{(NB-BPW){1'b0}}, st_be} << (int'(st_word) * BPW);
  assign wr_data = {WPE{st_data}};

  // tag lookup for the store port and the read port
  logic [DEPTH-1:0] st_hit_vec, rd_hit_vec;

  merge_wbuf_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_st_match (
    .tags(ent_tag), .occ(ent_occ), .key(st_tag), .hit(st_hit_vec)
  );

  merge_wbuf_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_rd_match (
    .tags(ent_tag), .occ(ent_occ), .key(rd_addr), .hit(rd_hit_vec)
  );

  // the slot on the drain port is closed to merges
  logic [DEPTH-1:0] lock_vec, merge_vec;
  logic [PTR_W-1:0] merge_idx;
  logic             merge_hit;

  always_comb begin
    lock_vec = '0;
    if (drn_q == DRN_BUSY) lock_vec[head] = 1'b1;
  end

  assign merge_vec = st_hit_vec & ~lock_vec;
  assign merge_hit = |merge_vec;

  always_comb begin
    merge_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (merge_vec[i]) merge_idx = PTR_W'(i);
    end
  end

  logic full, store_fire, alloc, drain_fire, drain_start;
  logic [PTR_W-1:0] wr_idx;

  assign full        = (cnt == CNT_W'(DEPTH));
  assign st_ready    = merge_hit || !full;
  assign store_fire  = st_valid && st_ready;
  assign alloc       = store_fire && !merge_hit;
  assign wr_idx      = merge_hit ? merge_idx : tail;
  assign drain_fire  = (drn_q == DRN_BUSY) && dr_ready;
  assign drain_start = (drn_q == DRN_IDLE) && (cnt != '0) && !(rd_req && !rd_hit);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  // slot contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_occ  <= '0;
      ent_tag  <= '0;
      ent_mask <= '0;
      ent_data <= '0;
    end else begin
      if (drain_fire) begin
        ent_occ[head]  <= 1'b0;
        ent_mask[head] <= '0;
      end
      if (store_fire) begin
        if (alloc) begin
          ent_occ[wr_idx]  <= 1'b1;
          ent_tag[wr_idx]  <= st_tag;
          ent_mask[wr_idx] <= wr_mask;
        end else begin
          ent_mask[wr_idx] <= ent_mask[wr_idx] | wr_mask;
        end
        for (int b = 0; b < NB; b++) begin
          if (wr_mask[b]) ent_data[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  // pointers, occupancy, drain state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
      drn_q <= DRN_IDLE;
    end else begin
      if (alloc)      tail <= bump(tail);
      if (drain_fire) head <= bump(head);
      case ({alloc, drain_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (drain_fire)       drn_q <= DRN_IDLE;
      else if (drain_start) drn_q <= DRN_BUSY;
    end
  end

  assign dr_valid = (drn_q == DRN_BUSY);
  assign dr_addr  = ent_tag[head];
  assign dr_mask  = ent_mask[head];
  assign dr_data  = ent_data[head];

  // read forwarding
  assign rd_hit = |rd_hit_vec;

  merge_wbuf_fwd #(.DEPTH(DEPTH), .NB(NB), .PTR_W(PTR_W)) u_fwd (
    .sel(rd_hit_vec), .masks(ent_mask), .datas(ent_data), .head(head),
    .out_mask(rd_mask), .out_data(rd_data)
  );
endmodule

// File: rtl/merge_wbuf_checker.sv
module merge_wbuf_checker #(
  parameter int TAG_W = 28,
  parameter int NB    = 16,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_ready,
  input logic             dr_valid,
  input logic             dr_ready,
  input logic [TAG_W-1:0] dr_addr,
  input logic [NB*8-1:0]  dr_data,
  input logic [NB-1:0]    dr_mask,
  input logic             rd_req,
  input logic             rd_hit,
  input logic [NB-1:0]    rd_mask,
  input logic [CNT_W-1:0] occ
);
  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_mask) && $stable(dr_data));

  assert_read_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_hit && !dr_valid |=> !dr_valid);

  assert_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> occ == CNT_W'(DEPTH));

  assert_fwd_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_mask != '0);

  assert_drain_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> dr_mask != '0);

  assert_empty_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> !dr_valid && !rd_hit);
endmodule

bind merge_wbuf merge_wbuf_checker #(
  .TAG_W(TAG_W), .NB(NB), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready),
  .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
  .dr_data(dr_data), .dr_mask(dr_mask),
  .rd_req(rd_req), .rd_hit(rd_hit), .rd_mask(rd_mask), .occ(cnt)
);

// File: tb/tb_merge_wbuf.sv
`timescale 1ns/1ps
module tb_merge_wbuf;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [29:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic [3:0]   st_be = '0;
  logic         dr_valid;
  logic         dr_ready = 1'b0;
  logic [27:0]  dr_addr;
  logic [127:0] dr_data;
  logic [15:0]  dr_mask;
  logic         rd_req = 1'b0;
  logic [27:0]  rd_addr = '0;
  logic         rd_hit;
  logic [15:0]  rd_mask;
  logic [127:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  merge_wbuf dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_mask(dr_mask),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_hit(rd_hit),
    .rd_mask(rd_mask), .rd_data(rd_data)
  );

  function automatic logic [127:0] bytes_of(input logic [15:0] m);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic store(input logic [27:0] tag, input logic [1:0] w,
                       input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_addr = {tag, w}; st_data = d; st_be = be;
    for (int i = 0; i < 100 && !st_ready; i++) @(negedge clk);
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic drain_one(input string req, input logic [27:0] tag,
                           input logic [15:0] m, input logic [127:0] d);
    @(negedge clk);
    dr_ready = 1'b1;
    for (int i = 0; i < 100 && !dr_valid; i++) @(negedge clk);
    chk(req, "drain valid", 128'(dr_valid), 128'(1));
    chk(req, "drain tag", 128'(dr_addr), 128'(tag));
    chk(req, "drain mask", 128'(dr_mask), 128'(m));
    chk(req, "drain data", dr_data & bytes_of(m), d & bytes_of(m));
    @(posedge clk);
    #1 dr_ready = 1'b0;
  endtask

  task automatic t_reset;
    tick(1);
    chk("R1", "dr_valid", 128'(dr_valid), 128'(0));
    chk("R1", "rd_hit", 128'(rd_hit), 128'(0));
    chk("R1", "st_ready", 128'(st_ready), 128'(1));
  endtask

  task automatic t_merge_priority;
    rd_req = 1'b1; rd_addr = 28'hF00;
    store(28'h100, 2'd0, 32'h11223344, 4'hF);
    store(28'h100, 2'd1, 32'hAABBCCDD, 4'h3);
    tick(5);
    chk("R7", "no drain while read miss", 128'(dr_valid), 128'(0));
    rd_addr = 28'h100;
    tick(1);
    chk("R8", "fwd hit", 128'(rd_hit), 128'(1));
    chk("R2", "fwd mask lanes", 128'(rd_mask), 128'(16'h003F));
    chk("R8", "fwd data", rd_data & bytes_of(16'h003F),
        128'h0000CCDD_11223344 & bytes_of(16'h003F));
    rd_req = 1'b0;
    drain_one("R3", 28'h100, 16'h003F, 128'h0000CCDD_11223344);
    tick(3);
    chk("R10", "empty after drain", 128'(dr_valid), 128'(0));
    chk("R10", "no hit after drain", 128'(rd_hit), 128'(0));
  endtask

  task automatic t_full_order;
    rd_req = 1'b1; rd_addr = 28'hF00;
    for (int i = 0; i < 4; i++)
      store(28'h200 + 28'(i) * 28'h100, 2'd0, 32'h10 + 32'(i), 4'h1);
    @(negedge clk);
    st_valid = 1'b1; st_addr = {28'h600, 2'd0}; st_be = 4'hF;
    #0.5;
    chk("R4", "full no match ready", 128'(st_ready), 128'(0));
    st_addr = {28'h300, 2'd2};
    #0.5;
    chk("R4", "full with match ready", 128'(st_ready), 128'(1));
    st_valid = 1'b0;
    store(28'h300, 2'd2, 32'h55667788, 4'hF);
    store(28'h300, 2'd2, 32'h99000000, 4'h8);
    rd_req = 1'b0;
    drain_one("R5", 28'h200, 16'h0001, 128'h10);
    drain_one("R5", 28'h300, 16'h0F01, {32'h0, 32'h99667788, 32'h0, 32'h11});
    drain_one("R5", 28'h400, 16'h0001, 128'h12);
    drain_one("R5", 28'h500, 16'h0001, 128'h13);
  endtask

  task automatic t_lock;
    logic [27:0] held;
    rd_req = 1'b0;
    store(28'h700, 2'd0, 32'h000000A1, 4'hF);
    for (int i = 0; i < 20 && !dr_valid; i++) @(negedge clk);
    held = dr_addr;
    tick(3);
    chk("R6", "valid held", 128'(dr_valid), 128'(1));
    chk("R6", "tag held", 128'(dr_addr), 128'(held));
    chk("R6", "mask held", 128'(dr_mask), 128'(16'h000F));
    store(28'h700, 2'd1, 32'h000000B2, 4'hF);
    store(28'h700, 2'd0, 32'h000000C3, 4'h1);
    chk("R9", "locked slot untouched", 128'(dr_mask), 128'(16'h000F));
    rd_req = 1'b1; rd_addr = 28'h700;
    tick(1);
    chk("R8", "fwd union mask", 128'(rd_mask), 128'(16'h00FF));
    chk("R8", "fwd newest wins", rd_data & bytes_of(16'h00FF),
        128'h000000B2_000000C3);
    rd_req = 1'b0;
    drain_one("R9", 28'h700, 16'h000F, 128'h000000A1);
    drain_one("R9", 28'h700, 16'h00F1, 128'h000000B2_000000C3);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_merge_priority();
    t_full_order();
    t_lock();
    tick(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule